// File: doc/BRIEF.md
# Pipelined Burst SRAM Control Front-End

This block is the synchronous control path of a pipelined burst SRAM, built around a small internal byte-lane memory. Every rising clock edge it samples three chip enables, two address strobes, an advance input and the write controls. From these it decides whether to start a new access, step the current burst, hold, or drop into the deselected state. A 2-bit burst counter drives the two low bits of the internal address. It steps in linear order by default, and a parameter selects interleaved order instead.

Writes take the data on `dq_in` at the same edge that performs them and go to the address in effect after that edge. Reads are pipelined: the word at an address captured on one edge is registered on the next edge and appears on `dq_out` after it. The read data drives the bus only when `dq_oe` is high. That signal follows the asynchronous output enable, but it is held low on the first cycle after the device is selected out of the deselected state, and whenever the current cycle is a write.

Top module: `sbsram_ctrl`

## Requirements
- R1: After reset, `dq_oe` is 0, `wr_be` is 0 and `burst_addr` is 0.
- R2: When the device is selected (`ce1_n`=0, `ce2`=1, `ce3_n`=0) and `adsc_n` or `adsp_n` is 0 at a rising edge, `burst_addr` equals the sampled `addr` after that edge.
- R3: When `ce1_n` is 1, a low `adsp_n` is ignored: with `adsc_n` and `adv_n` both 1, `burst_addr` and the output state are unchanged.
- R4: A strobe taken while any chip enable is inactive deselects the device. In that cycle `wr_be` is 0 and memory is not written, and from the second cycle after that edge `dq_oe` stays 0.
- R5: With both strobes 1 and `adv_n` 0, the two low bits of `burst_addr` step in linear order ((start + n) mod 4), and the upper bits hold.
- R6: With INTERLEAVE=1, the low bits step as (start XOR n).
- R7: With both strobes and `adv_n` at 1, `burst_addr` keeps its value.
- R8: While the device is active for the cycle, `gw_n`=0 gives `wr_be`=4'b1111, whatever `bwe_n` and `bw_n` show.
- R9: With `gw_n`=1 and `bwe_n`=0, `wr_be` bit i equals the inverse of `bw_n` bit i (bit i is byte lane i, bits 8i+7:8i of the data). With `bwe_n`=1 and `gw_n`=1, `wr_be` is 0 and the cycle is a read.
- R10: Only the enabled byte lanes of a write are stored. A read captured at edge k shows the stored word on `dq_out`, with `dq_oe` high, after edge k+1.
- R11: `oe_n`=1 forces `dq_oe` to 0 at once, without waiting for a clock edge.
- R12: On the first cycle after a read is selected out of the deselected state, `dq_oe` is 0 even with `oe_n` low.
- R13: While `wr_be` is non-zero, `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce1_n | input | 1 | Chip enable, active low; also gates `adsp_n` |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | AW (18) | Word address |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | NB (4) | Per-lane byte-write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | DW (32) | Write data from the bus |
| dq_out | output | DW (32) | Registered read data |
| dq_oe | output | 1 | Bus driver enable for `dq_out` |
| wr_be | output | NB (4) | Per-lane write strobes for this cycle |
| burst_addr | output | AW (18) | Current access address, burst counter in bits 1:0 |

## Verification
The hardest state to reach from the ports is the masked first cycle: the bus must stay quiet while `oe_n` is low and an older read value still sits in the output register. The bench gets there by running a read, forcing a deselect with `ce2` low, and then selecting a fresh read with `oe_n` already low. It does this before every one of the 64 readback addresses. A second instance with interleaved order runs the same burst sweep over all four start offsets, so both counter orders are compared with arithmetic expectations.

// File: rtl/sbsram_pkg.sv
// Shared types and helpers for the burst SRAM control front-end.
// Assumes the burst counter is two bits wide (bursts of four words).
package sbsram_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_STEP  = 2'd2,
        CMD_DESEL = 2'd3
    } cmd_e;

    // Low address bits for burst position cnt from start offset off.
    function automatic logic [1:0] burst_low(input logic [1:0] off,
                                             input logic [1:0] cnt,
                                             input bit         ilv);
        return ilv ? (off ^ cnt) : (off + cnt);
    endfunction

endpackage

// File: rtl/sbsram_cmd.sv
// Per-edge command decode from chip enables, strobes and advance.
// Assumes all inputs are sampled by the caller on the same rising edge.
module sbsram_cmd
    import sbsram_pkg::*;
(
    input  logic ce1_n,
    input  logic ce2,
    input  logic ce3_n,
    input  logic adsp_n,
    input  logic adsc_n,
    input  logic adv_n,
    output cmd_e cmd
);
    logic sel;
    logic strobe;

    // Processor strobe counts only while ce1_n is low.
    always_comb begin
        sel    = !ce1_n && ce2 && !ce3_n;
        strobe = (!adsp_n && !ce1_n) || !adsc_n;
    end

    // Priority: strobe (load or deselect), then advance, then hold.
    always_comb begin
        if (strobe)      cmd = sel ? CMD_LOAD : CMD_DESEL;
        else if (!adv_n) cmd = CMD_STEP;
        else             cmd = CMD_HOLD;
    end
endmodule

// File: rtl/sbsram_addr.sv
// Held address register with a 2-bit burst counter on the low bits.
// Provides the current address and the address in effect after this edge.
// Assumes AW >= 3.
module sbsram_addr
    import sbsram_pkg::*;
#(
    parameter int AW         = 18,
    parameter bit INTERLEAVE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cmd_e          cmd,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_q,
    output logic [AW-1:0] addr_nx
);
    localparam int HW = AW - 2;

    logic [HW-1:0] hi_q, hi_d;
    logic [1:0]    off_q, off_d;
    logic [1:0]    cnt_q, cnt_d;

    // Next-state for upper bits, start offset and burst position.
    always_comb begin
        hi_d  = hi_q;
        off_d = off_q;
        cnt_d = cnt_q;
        case (cmd)
            CMD_LOAD: begin
                hi_d  = addr_in[AW-1:2];
                off_d = addr_in[1:0];
                cnt_d = 2'd0;
            end
            CMD_STEP: cnt_d = cnt_q + 2'd1;
            default: ;
        endcase
    end

    // Address register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            off_q <= '0;
            cnt_q <= '0;
        end else begin
            hi_q  <= hi_d;
            off_q <= off_d;
            cnt_q <= cnt_d;
        end
    end

    // Compose the current and next addresses from the counter order.
    always_comb begin
        addr_q  = {hi_q, burst_low(off_q, cnt_q, INTERLEAVE)};
        addr_nx = {hi_d, burst_low(off_d, cnt_d, INTERLEAVE)};
    end
endmodule

// File: rtl/sbsram_wdec.sv
// Write-enable decode: global write overrides per-lane selects,
// per-lane selects need the byte-write enable. Gated by en.
module sbsram_wdec #(
    parameter int NB = 4
) (
    input  logic          en,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    output logic [NB-1:0] be
);
    for (genvar i = 0; i < NB; i++) begin : g_lane
        // One lane's strobe.
        always_comb be[i] = en && (!gw_n || (!bwe_n && !bw_n[i]));
    end
endmodule

// File: rtl/sbsram_array.sv
// Byte-lane memory with a registered read port.
// Assumes DW is a multiple of NB; depth is 2**MAW words.
module sbsram_array #(
    parameter int DW  = 32,
    parameter int NB  = 4,
    parameter int MAW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NB-1:0]  we,
    input  logic [MAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [MAW-1:0] raddr,
    output logic [DW-1:0]  rdata_q
);
    localparam int LW    = DW / NB;
    localparam int DEPTH = 1 << MAW;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];

        // Lane write.
        always_ff @(posedge clk) begin
            if (we[i]) mem[waddr] <= wdata[i*LW +: LW];
        end

        // Lane output register.
        always_ff @(posedge clk) begin
            if (!rst_n) rdata_q[i*LW +: LW] <= '0;
            else        rdata_q[i*LW +: LW] <= mem[raddr];
        end
    end
endmodule

// File: rtl/sbsram_ctrl.sv
// Top of the burst SRAM control front-end. Decodes the per-edge
// command, keeps the active state, tracks the read pipeline and
// produces write strobes, burst address and bus driver enable.
// Assumes MAW <= AW; upper address bits above MAW are not stored.
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int AW         = 18,
    parameter int MAW        = 6,
    parameter int DW         = 32,
    parameter int NB         = 4,
    parameter bit INTERLEAVE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce1_n,
    input  logic          ce2,
    input  logic          ce3_n,
    input  logic          adsp_n,
    input  logic          adsc_n,
    input  logic          adv_n,
    input  logic [AW-1:0] addr,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    input  logic          oe_n,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic [NB-1:0] wr_be,
    output logic [AW-1:0] burst_addr
);
    cmd_e          cmd;
    logic          active_q, active_d;
    logic          rd_q, drv_q;
    logic          wr_now;
    logic [AW-1:0] addr_q, addr_nx;

    sbsram_cmd u_cmd (
        .ce1_n (ce1_n),
        .ce2   (ce2),
        .ce3_n (ce3_n),
        .adsp_n(adsp_n),
        .adsc_n(adsc_n),
        .adv_n (adv_n),
        .cmd   (cmd)
    );

    sbsram_addr #(.AW(AW), .INTERLEAVE(INTERLEAVE)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .addr_in(addr),
        .addr_q (addr_q),
        .addr_nx(addr_nx)
    );

    // Device is active for this cycle after a load or while not deselected.
    always_comb active_d = (cmd == CMD_LOAD) || (active_q && (cmd != CMD_DESEL));

    sbsram_wdec #(.NB(NB)) u_wdec (
        .en   (active_d),
        .gw_n (gw_n),
        .bwe_n(bwe_n),
        .bw_n (bw_n),
        .be   (wr_be)
    );

    always_comb wr_now = |wr_be;

    sbsram_array #(.DW(DW), .NB(NB), .MAW(MAW)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_be),
        .waddr  (addr_nx[MAW-1:0]),
        .wdata  (dq_in),
        .raddr  (addr_q[MAW-1:0]),
        .rdata_q(dq_out)
    );

    // Active state and two-stage read pipeline (issue, then drive).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            rd_q     <= 1'b0;
            drv_q    <= 1'b0;
        end else begin
            active_q <= active_d;
            rd_q     <= active_d && !wr_now;
            drv_q    <= rd_q;
        end
    end

    // Drivers: asynchronous enable, pipeline valid, never during a write.
    always_comb dq_oe = !oe_n && drv_q && !wr_now;

    always_comb burst_addr = addr_q;
endmodule

// File: rtl/sbsram_ctrl_chk.sv
// Property checker for sbsram_ctrl, attached by bind.
module sbsram_ctrl_chk #(
    parameter int AW = 18,
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce1_n,
    input logic          ce2,
    input logic          ce3_n,
    input logic          adsp_n,
    input logic          adsc_n,
    input logic          adv_n,
    input logic [AW-1:0] addr,
    input logic          gw_n,
    input logic          bwe_n,
    input logic          oe_n,
    input logic          dq_oe,
    input logic [NB-1:0] wr_be,
    input logic [AW-1:0] burst_addr
);
    logic sel;
    always_comb sel = !ce1_n && ce2 && !ce3_n;

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && (!adsc_n || !adsp_n)) |=> (burst_addr == $past(addr)));

    p_adsp_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n && !adsp_n && adsc_n && adv_n) |=> $stable(burst_addr));

    p_desel_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsc_n && !sel) |-> (wr_be == '0));

    p_upper_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n && adsc_n) |=> (burst_addr[AW-1:2] == $past(burst_addr[AW-1:2])));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n && adsc_n && adv_n) |=> $stable(burst_addr));

    p_global_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!gw_n && (wr_be != '0)) |-> (wr_be == {NB{1'b1}}));

    p_no_byte_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_n && bwe_n) |-> (wr_be == '0));

    p_oe_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    p_no_drive_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_be != '0) |-> !dq_oe);
endmodule

bind sbsram_ctrl sbsram_ctrl_chk #(.AW(AW), .NB(NB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .adsp_n    (adsp_n),
    .adsc_n    (adsc_n),
    .adv_n     (adv_n),
    .addr      (addr),
    .gw_n      (gw_n),
    .bwe_n     (bwe_n),
    .oe_n      (oe_n),
    .dq_oe     (dq_oe),
    .wr_be     (wr_be),
    .burst_addr(burst_addr)
);

// File: tb/sbsram_ctrl_tb.sv
// Self-checking bench: fill, byte-lane writes, masked readback sweep,
// burst orders on two instances, hold, ignored strobe, deselect, write-time drive.
module sbsram_ctrl_tb;
    localparam int AW = 18;
    localparam int DW = 32;
    localparam int NB = 4;
    localparam int MAW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n;
    logic [AW-1:0] addr;
    logic          gw_n, bwe_n, oe_n;
    logic [NB-1:0] bw_n;
    logic [DW-1:0] dq_in;
    logic [DW-1:0] dq_out, dq_out_i;
    logic          dq_oe, dq_oe_i;
    logic [NB-1:0] wr_be, wr_be_i;
    logic [AW-1:0] burst_addr, burst_addr_i;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] shadow [64];

    always #2 clk = !clk;

    sbsram_ctrl #(.AW(AW), .MAW(MAW), .DW(DW), .NB(NB), .INTERLEAVE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .addr(addr),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .wr_be(wr_be), .burst_addr(burst_addr)
    );

    sbsram_ctrl #(.AW(AW), .MAW(MAW), .DW(DW), .NB(NB), .INTERLEAVE(1'b1)) u_dut_ilv (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .addr(addr),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .dq_in(dq_in),
        .dq_out(dq_out_i), .dq_oe(dq_oe_i), .wr_be(wr_be_i), .burst_addr(burst_addr_i)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return {8'(a + 8'h11), 8'(~a), 8'(a ^ 8'h5A), 8'(a * 3)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
    endtask

    // Deselect, then select a read of a with oe_n low; leaves data on the bus.
    task automatic read_fresh(input int a, input bit check_mask);
        quiet(); ce2 = 1'b0; adsc_n = 1'b0; oe_n = 1'b0;
        tick();
        quiet(); adsc_n = 1'b0; addr = AW'(a);
        tick();
        if (check_mask) chk(dq_oe == 1'b0, "R12", {31'd0, dq_oe}, 32'd0);
        quiet();
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; quiet(); ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
        oe_n = 1'b0; addr = '0; dq_in = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk(dq_oe == 1'b0, "R1", {31'd0, dq_oe}, 32'd0);
        chk(wr_be == '0, "R1", {28'd0, wr_be}, 32'd0);
        chk(burst_addr == '0, "R1", 32'(burst_addr), 32'd0);

        // Fill with global writes (R8) and check capture (R2).
        for (int a = 0; a < 64; a++) begin
            quiet(); adsc_n = 1'b0; addr = AW'(a) | AW'(a << 8);
            gw_n = 1'b0; bwe_n = a[0]; bw_n = a[3:0]; dq_in = pat(a);
            #1 chk(wr_be == 4'hF, "R8", {28'd0, wr_be}, 32'hF);
            tick();
            chk(burst_addr == (AW'(a) | AW'(a << 8)), "R2", 32'(burst_addr), 32'(a | (a << 8)));
            shadow[a] = pat(a);
        end

        // Byte-lane writes for every mask (R9).
        for (int m = 0; m < 16; m++) begin
            quiet(); adsc_n = 1'b0; addr = AW'(m);
            bwe_n = 1'b0; bw_n = ~4'(m); dq_in = 32'hC3E1_7700 + 32'(m);
            #1 chk(wr_be == 4'(m), "R9", {28'd0, wr_be}, 32'(m));
            tick();
            for (int l = 0; l < NB; l++)
                if (m[l]) shadow[m][l*8 +: 8] = dq_in[l*8 +: 8];
        end
        // R9: byte selects without byte-write enable do nothing.
        quiet(); adsc_n = 1'b0; addr = AW'(20); bw_n = '0; bwe_n = 1'b1; dq_in = '1;
        #1 chk(wr_be == '0, "R9", {28'd0, wr_be}, 32'd0);
        tick();
        quiet();

        // Readback sweep with first-cycle masking and async enable.
        for (int a = 0; a < 64; a++) begin
            read_fresh(a, 1'b1);
            chk(dq_oe && dq_out == shadow[a], "R10", dq_out, shadow[a]);
            oe_n = 1'b1;
            #1 chk(!dq_oe, "R11", {31'd0, dq_oe}, 32'd0);
            oe_n = 1'b0;
            #1 chk(dq_oe, "R11", {31'd0, dq_oe}, 32'd1);
        end

        // Bursts from every start offset on both counter orders.
        for (int off = 0; off < 4; off++) begin
            int base;
            int pl;
            int pi;
            base = 32 + off * 4;
            quiet(); ce2 = 1'b0; adsc_n = 1'b0;
            tick();
            quiet(); adsp_n = 1'b0; addr = AW'(base + off);
            tick();
            chk(burst_addr == AW'(base + off), "R2", 32'(burst_addr), 32'(base + off));
            chk(burst_addr_i == AW'(base + off), "R2", 32'(burst_addr_i), 32'(base + off));
            pl = base + off; pi = base + off;
            for (int n = 1; n < 4; n++) begin
                int el;
                int ei;
                quiet(); adv_n = 1'b0; addr = '1;
                tick();
                el = base + ((off + n) % 4);
                ei = base + (off ^ n);
                chk(burst_addr == AW'(el), "R5", 32'(burst_addr), 32'(el));
                chk(burst_addr_i == AW'(ei), "R6", 32'(burst_addr_i), 32'(ei));
                chk(dq_out == shadow[pl], "R10", dq_out, shadow[pl]);
                chk(dq_out_i == shadow[pi], "R10", dq_out_i, shadow[pi]);
                pl = el; pi = ei;
            end
            // R7: hold keeps the address, data of last step arrives.
            quiet();
            tick();
            chk(burst_addr == AW'(pl), "R7", 32'(burst_addr), 32'(pl));
            chk(dq_out == shadow[pl], "R10", dq_out, shadow[pl]);
            tick();
            chk(burst_addr == AW'(pl), "R7", 32'(burst_addr), 32'(pl));
            // R3: processor strobe with ce1_n high is ignored.
            ce1_n = 1'b1; adsp_n = 1'b0; addr = AW'(5);
            tick();
            chk(burst_addr == AW'(pl), "R3", 32'(burst_addr), 32'(pl));
            chk(dq_oe && dq_out == shadow[pl], "R3", dq_out, shadow[pl]);
        end

        // Deselect variants: no write, bus released.
        for (int v = 0; v < 4; v++) begin
            read_fresh(10, 1'b0);
            quiet(); addr = AW'(11); gw_n = 1'b0; dq_in = 32'hDEAD_BEEF;
            case (v)
                0: begin adsc_n = 1'b0; ce1_n = 1'b1; end
                1: begin adsc_n = 1'b0; ce2 = 1'b0; end
                2: begin adsc_n = 1'b0; ce3_n = 1'b1; end
                default: begin adsp_n = 1'b0; ce2 = 1'b0; end
            endcase
            #1 chk(wr_be == '0, "R4", {28'd0, wr_be}, 32'd0);
            tick();
            quiet(); gw_n = 1'b0;
            tick();
            tick();
            chk(!dq_oe && wr_be == '0, "R4", {31'd0, dq_oe}, 32'd0);
        end
        read_fresh(11, 1'b1);
        chk(dq_out == shadow[11], "R4", dq_out, shadow[11]);

        // R13: write while read data is pending keeps drivers off.
        read_fresh(12, 1'b0);
        chk(dq_oe, "R13", {31'd0, dq_oe}, 32'd1);
        gw_n = 1'b0; dq_in = 32'h1234_5678;
        #1 chk(wr_be == 4'hF && !dq_oe, "R13", {31'd0, dq_oe}, 32'd0);
        tick();
        shadow[12] = 32'h1234_5678;
        quiet();
        tick();
        tick();
        chk(dq_oe && dq_out == shadow[12], "R10", dq_out, shadow[12]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule